// File: doc/BRIEF.md
# Guest Interval Timer with Match

This block gives a guest a 64-bit time counter that it can read and rewrite without touching the host's own free-running count. The guest value is built as the host base count plus a stored offset. Each read is clamped against a floor value. The floor is raised whenever the match fires, so the guest never sees the counter step back past a delivered timer event.

A match register, compared on every cycle against the guest counter, raises a timer event. The event is turned into a request toward an interrupt controller through a vector register that holds an 8-bit vector and a mask bit. An event that lands while the mask is set is held in a sticky flag and delivered when software later clears the mask. Whenever the timer is re-armed, the block sends an unpend pulse so that the controller withdraws any stale request of the current vector.

The base count is an input, so the block follows whatever time source the chip provides. The counter value is presented combinationally on `cnt_o`.

Top module: `guest_timer_top`

## Requirements
- R1: `cnt_o` equals the stored offset plus `host_cnt_i` (modulo 2^64), except when that sum is below the floor value, in which case `cnt_o` equals the floor.
- R2: While `rst_n` is low, `cnt_o`, `pend_o` and `unpend_o` are 0. The vector register resets to masked (mask bit 16 set, vector 0) and the match value resets to 0. At the first clock edge after release, the offset is taken so that the counter reads 0 at the base count present on that edge.
- R3: A counter write of value V while the base count is H makes `cnt_o` equal V + (host_cnt_i − H) from the next cycle on, and sets the floor to 0.
- R4: A counter write re-arms the timer when the stored match value is greater than V, and then pulses `unpend_o` in the next cycle with the current vector. Otherwise it disarms the timer and no unpend pulse follows.
- R5: A match write of M arms the timer and pulses `unpend_o` in the next cycle when M is greater than the floor. A match that is already due then fires in the following cycle. When M is not greater than the floor, the match write disarms the timer and no pulse follows.
- R6: In a cycle with no write strobe, an armed timer whose match value is at or below `cnt_o` fires once and is disarmed. If the vector register is unmasked, `pend_o` pulses in the next cycle, with `pend_vec_o` equal to the vector register bits [7:0].
- R7: A fire with the mask bit set produces no `pend_o` and sets the sticky flag. Any fire raises the floor to match + 1, so `cnt_o` reads at least match + 1 afterwards.
- R8: A vector register write with bit 16 clear while the sticky flag is set pulses `pend_o` in the next cycle with the newly written vector, and clears the flag. A later unmasked write does not pend again.
- R9: When several write strobes are high in one cycle, the counter write wins over the match write, which wins over the vector write. The losing writes are ignored.
- R10: `pend_o` and `unpend_o` are single-cycle pulses and are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cnt_i | input | 64 | Free-running base count |
| cnt_wr_i | input | 1 | Counter write strobe |
| cnt_wdata_i | input | 64 | New guest counter value |
| match_wr_i | input | 1 | Match write strobe |
| match_wdata_i | input | 64 | New match value |
| vctl_wr_i | input | 1 | Vector register write strobe |
| vctl_wdata_i | input | 17 | Vector register value: bits [7:0] vector, bit 16 mask |
| cnt_o | output | 64 | Guest counter read value |
| pend_o | output | 1 | Pend request pulse |
| pend_vec_o | output | 8 | Vector to pend |
| unpend_o | output | 1 | Withdraw request pulse |
| unpend_vec_o | output | 8 | Vector to withdraw |

## Verification
Each result has a fixed latency. `cnt_o` is combinational and reflects a counter write from the cycle after the write edge. An unpend pulse, and a pend caused by a vector write, appear in the cycle after the write edge. A timer fire is decided in a quiet cycle and registered at that cycle's end. A due match therefore pends one edge after the cycle that followed the arming write. The bench drives every input on the falling edge and samples on the falling edge that follows the edge producing the result, with one tick per stage of latency.

// File: rtl/guest_timer_pkg.sv
package guest_timer_pkg;
  localparam int VEC_W    = 8;
  localparam int MASK_POS = 16;
  localparam int CTL_W    = MASK_POS + 1;
  localparam logic [CTL_W-1:0] CTL_RESET = CTL_W'(1) << MASK_POS;
endpackage

// File: rtl/guest_timer_count.sv
module guest_timer_count #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] host_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             fire_i,
  input  logic [CNT_W-1:0] match_i,
  output logic [CNT_W-1:0] guest_o,
  output logic [CNT_W-1:0] floor_o
);
  logic [CNT_W-1:0] offset_q, offset_n;
  logic [CNT_W-1:0] floor_q, floor_n;
  logic             anch_q;
  logic             offset_en, floor_en;
  logic [CNT_W-1:0] raw_sum;

  // read path: offset + base, clamped to the floor
  always_comb begin
    raw_sum = offset_q + host_i;
    if (!anch_q)
      guest_o = '0;
    else if (raw_sum < floor_q)
      guest_o = floor_q;
    else
      guest_o = raw_sum;
  end

  assign floor_o = floor_q;

  always_comb begin
    offset_en = load_i | ~anch_q;
    offset_n  = load_i ? (load_val_i - host_i) : ('0 - host_i);
    floor_en  = load_i | fire_i;
    floor_n   = load_i ? '0 : (match_i + CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offset_q <= '0;
      floor_q  <= '0;
      anch_q   <= 1'b0;
    end else begin
      anch_q <= 1'b1;
      if (offset_en) offset_q <= offset_n;
      if (floor_en)  floor_q  <= floor_n;
    end
  end
endmodule

// File: rtl/guest_timer_match.sv
module guest_timer_match #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             mwr_i,
  input  logic [CNT_W-1:0] mwr_val_i,
  input  logic             quiet_i,
  input  logic [CNT_W-1:0] guest_i,
  input  logic [CNT_W-1:0] floor_i,
  output logic [CNT_W-1:0] match_o,
  output logic             armed_o,
  output logic             fire_o,
  output logic             arm_evt_o
);
  logic [CNT_W-1:0] match_q;
  logic             armed_q, armed_n, armed_en;
  logic             arm_by_load, arm_by_mwr;

  always_comb begin
    arm_by_load = load_i & (match_q > load_val_i);
    arm_by_mwr  = mwr_i & (mwr_val_i > floor_i);
    fire_o      = armed_q & quiet_i & (guest_i >= match_q);
    arm_evt_o   = arm_by_load | arm_by_mwr;
    armed_en    = load_i | mwr_i | fire_o;
    armed_n     = arm_evt_o;
  end

  assign match_o = match_q;
  assign armed_o = armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= '0;
      armed_q <= 1'b0;
    end else begin
      if (mwr_i)    match_q <= mwr_val_i;
      if (armed_en) armed_q <= armed_n;
    end
  end
endmodule

// File: rtl/guest_timer_vector.sv
module guest_timer_vector
  import guest_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vwr_i,
  input  logic [CTL_W-1:0] vwr_val_i,
  input  logic             fire_i,
  input  logic             arm_evt_i,
  output logic             masked_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             pend_o,
  output logic [VEC_W-1:0] pend_vec_o,
  output logic             unpend_o,
  output logic [VEC_W-1:0] unpend_vec_o
);
  logic [CTL_W-1:0] ctl_q;
  logic             sticky_q, sticky_n, sticky_en;
  logic             pend_q, pend_n;
  logic [VEC_W-1:0] pvec_q, pvec_n;
  logic             unp_q;
  logic [VEC_W-1:0] uvec_q;
  logic             release_hit;

  assign masked_o = ctl_q[MASK_POS];
  assign vec_o    = ctl_q[VEC_W-1:0];

  always_comb begin
    release_hit = vwr_i & ~vwr_val_i[MASK_POS] & sticky_q;
    pend_n      = release_hit | (fire_i & ~ctl_q[MASK_POS]);
    pvec_n      = release_hit ? vwr_val_i[VEC_W-1:0] : ctl_q[VEC_W-1:0];
    sticky_en   = release_hit | (fire_i & ctl_q[MASK_POS]);
    sticky_n    = ~release_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q    <= CTL_RESET;
      sticky_q <= 1'b0;
      pend_q   <= 1'b0;
      pvec_q   <= '0;
      unp_q    <= 1'b0;
      uvec_q   <= '0;
    end else begin
      pend_q <= pend_n;
      unp_q  <= arm_evt_i;
      if (vwr_i)     ctl_q    <= vwr_val_i;
      if (sticky_en) sticky_q <= sticky_n;
      if (pend_n)    pvec_q   <= pvec_n;
      if (arm_evt_i) uvec_q   <= ctl_q[VEC_W-1:0];
    end
  end

  assign pend_o       = pend_q;
  assign pend_vec_o   = pvec_q;
  assign unpend_o     = unp_q;
  assign unpend_vec_o = uvec_q;
endmodule

// File: rtl/guest_timer_top.sv
module guest_timer_top
  import guest_timer_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] host_cnt_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             match_wr_i,
  input  logic [CNT_W-1:0] match_wdata_i,
  input  logic             vctl_wr_i,
  input  logic [CTL_W-1:0] vctl_wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pend_o,
  output logic [VEC_W-1:0] pend_vec_o,
  output logic             unpend_o,
  output logic [VEC_W-1:0] unpend_vec_o
);
  logic             mwr_eff, vwr_eff, quiet;
  logic [CNT_W-1:0] guest_w, floor_w, match_w;
  logic             fire_w, armed_w, arm_evt_w, masked_w;
  logic [VEC_W-1:0] vec_w;

  // write priority: counter, then match, then vector register
  assign mwr_eff = match_wr_i & ~cnt_wr_i;
  assign vwr_eff = vctl_wr_i & ~cnt_wr_i & ~match_wr_i;
  assign quiet   = ~(cnt_wr_i | match_wr_i | vctl_wr_i);

  guest_timer_count #(.CNT_W(CNT_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_i     (host_cnt_i),
    .load_i     (cnt_wr_i),
    .load_val_i (cnt_wdata_i),
    .fire_i     (fire_w),
    .match_i    (match_w),
    .guest_o    (guest_w),
    .floor_o    (floor_w)
  );

  guest_timer_match #(.CNT_W(CNT_W)) u_match (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (cnt_wr_i),
    .load_val_i (cnt_wdata_i),
    .mwr_i      (mwr_eff),
    .mwr_val_i  (match_wdata_i),
    .quiet_i    (quiet),
    .guest_i    (guest_w),
    .floor_i    (floor_w),
    .match_o    (match_w),
    .armed_o    (armed_w),
    .fire_o     (fire_w),
    .arm_evt_o  (arm_evt_w)
  );

  guest_timer_vector u_vector (
    .clk          (clk),
    .rst_n        (rst_n),
    .vwr_i        (vwr_eff),
    .vwr_val_i    (vctl_wdata_i),
    .fire_i       (fire_w),
    .arm_evt_i    (arm_evt_w),
    .masked_o     (masked_w),
    .vec_o        (vec_w),
    .pend_o       (pend_o),
    .pend_vec_o   (pend_vec_o),
    .unpend_o     (unpend_o),
    .unpend_vec_o (unpend_vec_o)
  );

  assign cnt_o = guest_w;
endmodule

// File: rtl/guest_timer_checker.sv
module guest_timer_checker
  import guest_timer_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_wr_i,
  input logic [CNT_W-1:0] cnt_wdata_i,
  input logic [CNT_W-1:0] host_cnt_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic             mwr_eff,
  input logic [CNT_W-1:0] match_wdata_i,
  input logic [CNT_W-1:0] floor_w,
  input logic [CNT_W-1:0] match_w,
  input logic             armed_w,
  input logic             fire_w,
  input logic             arm_evt_w,
  input logic             masked_w,
  input logic [VEC_W-1:0] vec_w,
  input logic             pend_o,
  input logic [VEC_W-1:0] pend_vec_o,
  input logic             unpend_o
);
  a_r3_count_load: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_i |=> cnt_o == $past(cnt_wdata_i) + (host_cnt_i - $past(host_cnt_i)));

  a_r4_unpend_after_arm: assert property (@(posedge clk) disable iff (!rst_n)
    arm_evt_w |=> unpend_o);

  a_r5_low_match_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (mwr_eff && !(match_wdata_i > floor_w)) |=> !armed_w);

  a_r6_pend_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_w && !masked_w) |=> (pend_o && pend_vec_o == $past(vec_w)));

  a_r7_masked_fire_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_w && masked_w) |=> !pend_o);

  a_r7_floor_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
    fire_w |=> cnt_o > $past(match_w));

  a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend_o && unpend_o));
endmodule

bind guest_timer_top guest_timer_checker #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cnt_wr_i      (cnt_wr_i),
  .cnt_wdata_i   (cnt_wdata_i),
  .host_cnt_i    (host_cnt_i),
  .cnt_o         (cnt_o),
  .mwr_eff       (mwr_eff),
  .match_wdata_i (match_wdata_i),
  .floor_w       (floor_w),
  .match_w       (match_w),
  .armed_w       (armed_w),
  .fire_w        (fire_w),
  .arm_evt_w     (arm_evt_w),
  .masked_w      (masked_w),
  .vec_w         (vec_w),
  .pend_o        (pend_o),
  .pend_vec_o    (pend_vec_o),
  .unpend_o      (unpend_o)
);

// File: tb/sim_guest_timer_top.sv
`timescale 1ns/1ps
module sim_guest_timer_top;
  logic        clk;
  logic        rst_n;
  logic [63:0] host;
  logic        cnt_wr, match_wr, vctl_wr;
  logic [63:0] cnt_wd, match_wd;
  logic [16:0] vctl_wd;
  logic [63:0] cnt;
  logic        pend, unpend;
  logic [7:0]  pvec, uvec;
  int          checks;
  int          errors;
  bit          done;

  guest_timer_top u0 (
    .clk(clk), .rst_n(rst_n), .host_cnt_i(host),
    .cnt_wr_i(cnt_wr), .cnt_wdata_i(cnt_wd),
    .match_wr_i(match_wr), .match_wdata_i(match_wd),
    .vctl_wr_i(vctl_wr), .vctl_wdata_i(vctl_wd),
    .cnt_o(cnt), .pend_o(pend), .pend_vec_o(pvec),
    .unpend_o(unpend), .unpend_vec_o(uvec)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // columns: base at write, value written, base at read, expected read
  localparam logic [63:0] LOADS [0:3][0:3] = '{
    '{64'd100,  64'd5000,                 64'd150, 64'd5050},
    '{64'd200,  64'd0,                    64'd200, 64'd0},
    '{64'd7,    64'hFFFF_FFFF_0000_0000,  64'd17,  64'hFFFF_FFFF_0000_000A},
    '{64'd1000, 64'd50,                   64'd990, 64'd40}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_cnt(input logic [63:0] v);
    cnt_wr = 1'b1; cnt_wd = v;
    tick();
    cnt_wr = 1'b0;
  endtask

  task automatic wr_match(input logic [63:0] v);
    match_wr = 1'b1; match_wd = v;
    tick();
    match_wr = 1'b0;
  endtask

  task automatic wr_vctl(input logic [16:0] v);
    vctl_wr = 1'b1; vctl_wd = v;
    tick();
    vctl_wr = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; host = 64'd1000;
    cnt_wr = 0; match_wr = 0; vctl_wr = 0;
    cnt_wd = '0; match_wd = '0; vctl_wd = '0;
    repeat (3) @(negedge clk);
    chk("R2 count in reset", cnt, 64'd0);
    chk("R2 pend in reset", {63'd0, pend}, 64'd0);
    chk("R2 unpend in reset", {63'd0, unpend}, 64'd0);
    rst_n = 1'b1;
    tick();
    chk("R2 count anchored at zero", cnt, 64'd0);
    host = 64'd1010; #1;
    chk("R1 count follows base", cnt, 64'd10);

    // table of counter loads
    for (int i = 0; i < 4; i++) begin
      host = LOADS[i][0];
      wr_cnt(LOADS[i][1]);
      chk("R4 no unpend when match not ahead", {63'd0, unpend}, 64'd0);
      host = LOADS[i][2]; #1;
      chk("R3 loaded count", cnt, LOADS[i][3]);
    end

    // masked fire, floor clamp, deferred delivery
    host = 64'd0;
    wr_cnt(64'd0);
    wr_match(64'd20);
    chk("R5 arm unpend", {63'd0, unpend}, 64'd1);
    chk("R5 unpend vector", {56'd0, uvec}, 64'd0);
    host = 64'd30;
    tick();
    chk("R7 R2 masked fire does not pend", {63'd0, pend}, 64'd0);
    host = 64'd10; #1;
    chk("R1 R7 read clamped to match+1", cnt, 64'd21);
    wr_vctl(17'h00045);
    chk("R8 deferred pend", {63'd0, pend}, 64'd1);
    chk("R8 deferred vector", {56'd0, pvec}, 64'h45);
    tick();
    chk("R10 pend single pulse", {63'd0, pend}, 64'd0);
    wr_vctl(17'h00046);
    chk("R8 sticky cleared", {63'd0, pend}, 64'd0);

    // unmasked fire
    host = 64'd10;
    wr_cnt(64'd100);
    chk("R4 disarm no unpend", {63'd0, unpend}, 64'd0);
    wr_match(64'd150);
    chk("R5 arm unpend", {63'd0, unpend}, 64'd1);
    chk("R5 unpend vector", {56'd0, uvec}, 64'h46);
    tick();
    chk("R6 not yet due", {63'd0, pend}, 64'd0);
    host = 64'd60;
    tick();
    chk("R6 fire pends", {63'd0, pend}, 64'd1);
    chk("R6 fire vector", {56'd0, pvec}, 64'h46);
    tick();
    chk("R10 R6 fires once", {63'd0, pend}, 64'd0);
    chk("R7 floor after fire", cnt, 64'd151);

    // low match disarms, past match fires at once
    wr_match(64'd100);
    chk("R5 low match no unpend", {63'd0, unpend}, 64'd0);
    host = 64'd200;
    tick();
    chk("R5 low match disarmed", {63'd0, pend}, 64'd0);
    wr_match(64'd152);
    chk("R5 past match arms", {63'd0, unpend}, 64'd1);
    tick();
    chk("R5 past match due now", {63'd0, pend}, 64'd1);

    // counter write re-arms against stored match
    wr_cnt(64'd10);
    chk("R4 rearm unpend", {63'd0, unpend}, 64'd1);
    chk("R4 rearm unpend vector", {56'd0, uvec}, 64'h46);
    tick();
    chk("R4 rearmed not due", {63'd0, pend}, 64'd0);
    host = 64'd342;
    tick();
    chk("R4 rearmed fires", {63'd0, pend}, 64'd1);

    // write priority
    cnt_wr = 1'b1; cnt_wd = 64'd1000; match_wr = 1'b1; match_wd = 64'd2000;
    tick();
    cnt_wr = 1'b0; match_wr = 1'b0;
    chk("R9 match write ignored, no arm", {63'd0, unpend}, 64'd0);
    chk("R9 counter write applied", cnt, 64'd1000);
    host = 64'd1342;
    tick();
    chk("R9 ignored match never fires", {63'd0, pend}, 64'd0);
    match_wr = 1'b1; match_wd = 64'd2100; vctl_wr = 1'b1; vctl_wd = 17'h00022;
    tick();
    match_wr = 1'b0; vctl_wr = 1'b0;
    chk("R9 match beats vector, unpend", {63'd0, unpend}, 64'd1);
    chk("R9 unpend uses old vector", {56'd0, uvec}, 64'h46);
    host = 64'd1442;
    tick();
    chk("R9 fire pends", {63'd0, pend}, 64'd1);
    chk("R9 vector write ignored", {56'd0, pvec}, 64'h46);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule